// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two 16-bit bidirectional buses, A and B. Each direction has its own capture register: the forward register holds data taken from bus A, and the reverse register holds data taken from bus B. Each register loads on the rising edge of its own capture clock. A capture clock edge always loads its register, whatever the drive enables are doing. A source select per direction chooses what the block drives onto the far bus. It can drive the live value of the near bus, or the value held in that direction's register. A drive enable per direction decides whether the far bus is driven at all. The forward enable is active-high and the reverse enable is active-low. When both enables are inactive, both buses are isolated inputs.

All controls come in two copies, one for bits 7:0 (lane 0) and one for bits 15:8 (lane 1). Each byte lane works on its own, and tying the pairs together gives 16-bit operation. Each bus pin is modelled as three signals: an input value, an output value and a per-bit drive enable. A register always samples the value present on its bus. If the block drives that bus, this is the driven value, so one direction can load the same data into both registers. Selects and enables act combinationally. The registers have no reset. The house style asks for valid/ready streams, but that does not fit pin-level bus routing, so all pins are plain.

Top module: `bus_xcvr_dual_reg`

## Requirements
- R1: On a rising edge of `fwd_clk[l]`, lane l of the forward register loads the lane-l value present on bus A.
- R2: On a rising edge of `rev_clk[l]`, lane l of the reverse register loads the lane-l value present on bus B.
- R3: Capture works with any enable setting, including isolation (`fwd_en[l]`=0, `rev_en_n[l]`=1), where neither bus lane is driven.
- R4: All bits of `b_oe` in lane l equal `fwd_en[l]`: the B bus is driven only when the forward enable is 1.
- R5: All bits of `a_oe` in lane l equal the inverse of `rev_en_n[l]`: the A bus is driven only when the reverse enable is 0.
- R6: When B is driven and `fwd_sel[l]`=0, `b_out` carries the live A-bus value (`a_in` when A is not driven). When `fwd_sel[l]`=1, it carries the forward register.
- R7: When A is driven and `rev_sel[l]`=0, `a_out` carries the live B-bus value (`b_in` when B is not driven). When `rev_sel[l]`=1, it carries the reverse register.
- R8: Lanes 0 and 1 act independently under different control settings.
- R9: The bus value seen by a register is the block's own output when the block drives that bus. A rising edge on the reverse clock while only the forward direction drives B stores the A data into the reverse register, and the mirror case also holds.
- R10: When both directions are driven with both selects at 0, `b_out` carries `a_in` and `a_out` carries `b_in` for that lane.
- R11: Select and enable changes reach the outputs with no capture clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | External value on bus A |
| a_out | output | 16 | Value the block drives onto bus A |
| a_oe | output | 16 | Per-bit drive enable for bus A |
| b_in | input | 16 | External value on bus B |
| b_out | output | 16 | Value the block drives onto bus B |
| b_oe | output | 16 | Per-bit drive enable for bus B |
| fwd_clk | input | 2 | Per-lane capture clock of the forward register |
| rev_clk | input | 2 | Per-lane capture clock of the reverse register |
| fwd_sel | input | 2 | Per-lane B source: 0 live, 1 stored |
| rev_sel | input | 2 | Per-lane A source: 0 live, 1 stored |
| fwd_en | input | 2 | Per-lane B drive enable, active-high |
| rev_en_n | input | 2 | Per-lane A drive enable, active-low |

## Verification
The assertions check the routing on every evaluation. They check that an isolated lane drives nothing, that a stored select puts the register value onto the driven bus, and that a live select passes the undriven opposite input. They also check the cross swap when both directions are live. Only the bench scenarios can show what a capture edge stores. This includes the case where one direction loads both registers with the same data, the fact that capture continues during isolation, and the independence of the two lanes. The bench shows these by reading the registers back later through the stored-select paths.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  parameter int unsigned LANE_W = 8;
  parameter int unsigned LANES  = 2;
  localparam int unsigned BUS_W = LANE_W * LANES;
endpackage

// File: rtl/bus_xcvr_cap_reg.sv
module bus_xcvr_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         cap_clk,
  input  logic [W-1:0] bus_val,
  output logic [W-1:0] held
);
  // No reset: contents are unknown until the first capture edge.
  always_ff @(posedge cap_clk) begin
    held <= bus_val;
  end
endmodule

// File: rtl/bus_xcvr_lane_route.sv
module bus_xcvr_lane_route #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] fwd_held,
  input  logic [W-1:0] rev_held,
  input  logic         fwd_sel,
  input  logic         rev_sel,
  input  logic         fwd_en,
  input  logic         rev_en_n,
  output logic [W-1:0] a_seen,
  output logic [W-1:0] b_seen,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);
  logic drive_a, drive_b;

  assign drive_a = ~rev_en_n;
  assign drive_b = fwd_en;

  // Both buses are computed from inputs and registers only.
  // A live-to-live pair takes the other side's external input,
  // so the routing has no combinational loop.
  always_comb begin
    if (!drive_a)                 a_seen = a_in;
    else if (rev_sel)             a_seen = rev_held;
    else if (drive_b && fwd_sel)  a_seen = fwd_held;
    else                          a_seen = b_in;

    if (!drive_b)                 b_seen = b_in;
    else if (fwd_sel)             b_seen = fwd_held;
    else if (drive_a && rev_sel)  b_seen = rev_held;
    else                          b_seen = a_in;
  end

  assign a_oe = {W{drive_a}};
  assign b_oe = {W{drive_b}};

  always_comb begin
    if (!$isunknown({fwd_en, rev_en_n}) && !fwd_en && rev_en_n)
      AST_ISOLATED_NO_DRIVE: assert (a_oe == '0 && b_oe == '0); // R3
    if (!$isunknown({fwd_en, fwd_sel}) && fwd_en && fwd_sel && !$isunknown(fwd_held))
      AST_STORED_TO_B: assert (b_seen == fwd_held); // R6
    if (!$isunknown({rev_en_n, rev_sel}) && !rev_en_n && rev_sel && !$isunknown(rev_held))
      AST_STORED_TO_A: assert (a_seen == rev_held); // R7
    if (!$isunknown({fwd_en, fwd_sel, rev_en_n}) && fwd_en && !fwd_sel && rev_en_n)
      AST_LIVE_TO_B: assert (b_seen == a_in); // R6
    if (!$isunknown({rev_en_n, rev_sel, fwd_en}) && !rev_en_n && !rev_sel && !fwd_en)
      AST_LIVE_TO_A: assert (a_seen == b_in); // R7
    if (!$isunknown({fwd_en, fwd_sel, rev_en_n, rev_sel}) && fwd_en && !fwd_sel && !rev_en_n && !rev_sel)
      AST_CROSS_SWAP: assert (a_seen == b_in && b_seen == a_in); // R10
  end
endmodule

// File: rtl/bus_xcvr_dual_reg.sv
module bus_xcvr_dual_reg
  import bus_xcvr_pkg::*;
(
  input  logic [BUS_W-1:0] a_in,
  output logic [BUS_W-1:0] a_out,
  output logic [BUS_W-1:0] a_oe,
  input  logic [BUS_W-1:0] b_in,
  output logic [BUS_W-1:0] b_out,
  output logic [BUS_W-1:0] b_oe,
  input  logic [LANES-1:0] fwd_clk,
  input  logic [LANES-1:0] rev_clk,
  input  logic [LANES-1:0] fwd_sel,
  input  logic [LANES-1:0] rev_sel,
  input  logic [LANES-1:0] fwd_en,
  input  logic [LANES-1:0] rev_en_n
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] fwd_held, rev_held, a_seen, b_seen;

    bus_xcvr_lane_route #(.W(LANE_W)) i_route (
      .a_in     (a_in[l*LANE_W +: LANE_W]),
      .b_in     (b_in[l*LANE_W +: LANE_W]),
      .fwd_held (fwd_held),
      .rev_held (rev_held),
      .fwd_sel  (fwd_sel[l]),
      .rev_sel  (rev_sel[l]),
      .fwd_en   (fwd_en[l]),
      .rev_en_n (rev_en_n[l]),
      .a_seen   (a_seen),
      .b_seen   (b_seen),
      .a_oe     (a_oe[l*LANE_W +: LANE_W]),
      .b_oe     (b_oe[l*LANE_W +: LANE_W])
    );

    // Each register samples its bus as seen at the pin (R9).
    bus_xcvr_cap_reg #(.W(LANE_W)) i_fwd_reg (
      .cap_clk (fwd_clk[l]),
      .bus_val (a_seen),
      .held    (fwd_held)
    );

    bus_xcvr_cap_reg #(.W(LANE_W)) i_rev_reg (
      .cap_clk (rev_clk[l]),
      .bus_val (b_seen),
      .held    (rev_held)
    );

    assign a_out[l*LANE_W +: LANE_W] = a_seen;
    assign b_out[l*LANE_W +: LANE_W] = b_seen;
  end
endmodule

// File: tb/test_bus_xcvr_dual_reg.sv
module test_bus_xcvr_dual_reg;
  logic        clk = 1'b0;
  logic [15:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic [1:0]  fwd_clk, rev_clk, fwd_sel, rev_sel, fwd_en, rev_en_n;
  int unsigned errors = 0, checks = 0, cycles = 0;
  logic [7:0]  m_fwd [2];
  logic [7:0]  m_rev [2];

  always #10 clk = ~clk;

  bus_xcvr_dual_reg i_bus_xcvr_dual_reg (
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .fwd_clk(fwd_clk), .rev_clk(rev_clk),
    .fwd_sel(fwd_sel), .rev_sel(rev_sel),
    .fwd_en(fwd_en), .rev_en_n(rev_en_n)
  );

  // Bus value at pin A for lane l, from the requirements.
  function automatic logic [7:0] exp_a(int l);
    logic [7:0] ai = a_in[l*8 +: 8], bi = b_in[l*8 +: 8];
    if (rev_en_n[l])                 return ai;
    if (rev_sel[l])                  return m_rev[l];
    if (fwd_en[l] && fwd_sel[l])     return m_fwd[l];
    return bi;
  endfunction

  function automatic logic [7:0] exp_b(int l);
    logic [7:0] ai = a_in[l*8 +: 8], bi = b_in[l*8 +: 8];
    if (!fwd_en[l])                  return bi;
    if (fwd_sel[l])                  return m_fwd[l];
    if (!rev_en_n[l] && rev_sel[l])  return m_rev[l];
    return ai;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [15:0] ea, eb, eoa, eob;
    for (int l = 0; l < 2; l++) begin
      ea[l*8 +: 8]  = exp_a(l);
      eb[l*8 +: 8]  = exp_b(l);
      eoa[l*8 +: 8] = {8{~rev_en_n[l]}};
      eob[l*8 +: 8] = {8{fwd_en[l]}};
    end
    chk("R5 a_oe", a_oe, eoa);
    chk("R4 b_oe", b_oe, eob);
    chk({tag, " a_out"}, a_out & eoa, ea & eoa);
    chk({tag, " b_out"}, b_out & eob, eb & eob);
  endtask

  task automatic step(string tag, logic [15:0] a, logic [15:0] b,
                      logic [1:0] en, logic [1:0] enn, logic [1:0] fs,
                      logic [1:0] rs, logic [1:0] fc, logic [1:0] rc);
    logic [7:0] na [2];
    logic [7:0] nb [2];
    @(negedge clk);
    a_in = a; b_in = b; fwd_en = en; rev_en_n = enn; fwd_sel = fs; rev_sel = rs;
    #2 check_all(tag);                       // R11: no clock edge needed
    if (fc != 0 || rc != 0) begin
      for (int l = 0; l < 2; l++) begin na[l] = exp_a(l); nb[l] = exp_b(l); end
      #2;
      fwd_clk = fc; rev_clk = rc;
      for (int l = 0; l < 2; l++) begin
        if (fc[l]) m_fwd[l] = na[l];          // R1, R9
        if (rc[l]) m_rev[l] = nb[l];          // R2, R9
      end
      #2 check_all({tag, " post-edge"});
      @(posedge clk);
      fwd_clk = 2'b00; rev_clk = 2'b00;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    a_in = '0; b_in = '0; fwd_clk = '0; rev_clk = '0;
    fwd_sel = '0; rev_sel = '0; fwd_en = '0; rev_en_n = '1;
    m_fwd[0] = 'x; m_fwd[1] = 'x; m_rev[0] = 'x; m_rev[1] = 'x;
    // Reset state: isolation, nothing driven (R3, R4, R5)
    step("R3 isolation", 16'h1234, 16'h5678, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
    // R3, R1, R2: capture during isolation
    step("R3 capture", 16'hA55A, 16'h3CC3, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
    // R6, R7: stored data out both ways
    step("R6 R7 stored both", 16'h0000, 16'hFFFF, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    // R6: live A to B
    step("R6 live", 16'hBEEF, 16'h0F0F, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
    // R7: live B to A
    step("R7 live", 16'h1111, 16'hC0DE, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    // R9: only forward drives B; reverse clock stores A data in both registers
    step("R9 fwd both", 16'h6996, 16'h0000, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11);
    step("R9 readback", 16'h0000, 16'h0000, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    // R9 mirror: only reverse drives A
    step("R9 rev both", 16'h0000, 16'h7E81, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11);
    step("R9 mirror readback", 16'h0000, 16'h0000, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    // R10: both live
    step("R10 cross", 16'h1357, 16'h2468, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    // R8: lanes with different settings and one-lane clocks
    step("R8 lanes", 16'hAB12, 16'hCD34, 2'b01, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10);
    step("R8 lane readback", 16'h0000, 16'h0000, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
    // R11: select flips without clock
    step("R11 sel flip", 16'h4242, 16'h9999, 2'b11, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i < 400; i++) begin
      step("R6 R7 R8 random", 16'($urandom), 16'($urandom), 2'($urandom), 2'($urandom),
           2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule